// File: doc/BRIEF.md
# Second-Chance Victim Selector

This block chooses which physical frame to give up when memory needs a free frame. Frames are appended to a circular queue as they are loaded, so the queue holds them in order of arrival. Each frame also has a reference bit, which is set whenever that frame is accessed.

When a victim is requested, the engine walks the queue from its head, one candidate per clock. A candidate whose reference bit is set is given another round: its bit is cleared and it moves to the tail. The first candidate found with a clear bit is taken off the queue and reported as the victim. A reported frame comes back only through a later enqueue.

The surrounding memory manager drives four things: the enqueue port when it loads a frame, the reference port on every access, a bulk clear of all reference bits, and a request/response handshake for victims. Enqueued frame numbers are assumed to be distinct.

Top module: `sc_victim_sel`

## Requirements
- R1: After reset the queue is empty, every reference bit is clear, and `vic_busy`, `vic_valid` and `enq_err` are low. A `clr_all` pulse clears every reference bit, so the next search takes the head frame with no recycling.
- R2: A `ref_valid` pulse sets the reference bit of `ref_frame`. A reference takes priority over any clear of the same bit in the same cycle, including `clr_all`.
- R3: An enqueue accepted while idle and not full appends `enq_frame` at the tail and clears that frame's reference bit, unless the frame is referenced in the same cycle.
- R4: A search examines candidates in FIFO order starting at the head, which is the longest-resident frame, at one candidate per clock cycle.
- R5: A candidate whose reference bit is 1 has that bit cleared and is moved to the tail of the queue. The queue keeps its size.
- R6: The victim is the first candidate whose reference bit is 0, and it is removed from the queue. `vic_valid` is high for exactly one cycle, with `vic_frame` holding the victim. That cycle follows the k+1th rising edge after the edge that accepted the request, where k is the number of candidates recycled.
- R7: If every queued frame has its bit set, one full pass clears them all and the original head frame becomes the victim, with k equal to the queue size.
- R8: `vic_busy` is high from the cycle after a request is accepted until the cycle in which `vic_valid` is high, when it is low. A request made while busy, or while the queue is empty, is ignored.
- R9: The queue holds `NUM_FRAMES` entries and wraps around. An enqueue while the queue is full is not stored and raises `enq_err` for one cycle; `enq_err` is low after any accepted enqueue.
- R10: An enqueue presented while a search is in progress is ignored. It raises no error and does not enter the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Append a loaded frame |
| enq_frame | input | FW | Frame number to append |
| enq_err | output | 1 | Enqueue rejected because the queue is full |
| ref_valid | input | 1 | Access to a frame |
| ref_frame | input | FW | Frame that was accessed |
| clr_all | input | 1 | Clear all reference bits |
| vic_req | input | 1 | Request a victim |
| vic_busy | output | 1 | Search in progress |
| vic_valid | output | 1 | Victim reported this cycle |
| vic_frame | output | FW | Victim frame number |

## Verification
A wrong internal state of this block shows at the ports in a few ways. A corrupted queue order shows up as a wrong `vic_frame` in one of the following victims. A stale or lost reference bit changes the search latency by one cycle per wrongly recycled candidate, and it can also change the victim itself. These effects appear within one search of the fault, at most `NUM_FRAMES`+1 cycles later. Draining the whole queue after each case exposes any misplaced tail entry within `NUM_FRAMES` more searches. A broken count shows as a missing or extra `enq_err` at the next enqueue on a full queue, or as an ignored request when the queue should not be empty.

// File: rtl/sc_pkg.sv
// Shared types for the second-chance victim selector.
package sc_pkg;
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } sc_state_e;
endpackage

// File: rtl/sc_ring.sv
// Circular FIFO of frame numbers with simultaneous push and pop.
// Assumes: the caller never pushes alone when full, and never pops when empty.
module sc_ring #(
    parameter int DEPTH = 8,
    parameter int DW    = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_data = mem[head_q];
    assign full      = (count_q == CW'(DEPTH));
    assign empty     = (count_q == '0);

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= wrap_inc(tail_q);
            if (pop)  head_q <= wrap_inc(head_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Write the pushed entry at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[tail_q] <= push_data;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sc_refbits.sv
// One reference bit per frame: set on access, cleared singly or all at once.
// Assumes: a set wins over both kinds of clear in the same cycle.
module sc_refbits #(
    parameter int N  = 8,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [FW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [FW-1:0] clr_idx,
    input  logic          clr_all,
    output logic [N-1:0]  bits
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Update the reference bit of frame i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[i] <= 1'b0;
            else if (set_en && set_idx == FW'(i))
                bits[i] <= 1'b1;
            else if (clr_all || (clr_en && clr_idx == FW'(i)))
                bits[i] <= 1'b0;
        end
    end

    // R1
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_en) |=> (bits == '0));
    // R2
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (bits[$past(set_idx)] == 1'b1));
endmodule

// File: rtl/sc_victim_sel.sv
// Second-chance victim selector: a FIFO of resident frames plus reference bits.
// A search walks the queue head one candidate per cycle, recycling referenced
// frames to the tail and removing the first unreferenced one as the victim.
// Assumes: enqueued frame numbers are distinct and below NUM_FRAMES.
module sc_victim_sel #(
    parameter int NUM_FRAMES = 8,
    localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int SW = $clog2(NUM_FRAMES + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_valid,
    input  logic [FW-1:0] enq_frame,
    output logic          enq_err,
    input  logic          ref_valid,
    input  logic [FW-1:0] ref_frame,
    input  logic          clr_all,
    input  logic          vic_req,
    output logic          vic_busy,
    output logic          vic_valid,
    output logic [FW-1:0] vic_frame
);
    import sc_pkg::*;

    sc_state_e       state_q;
    logic [FW-1:0]   head_frame;
    logic [NUM_FRAMES-1:0] ref_bits;
    logic            q_full, q_empty;
    logic            idle, scan, enq_ok, enq_rej, start, head_ref, rotate, take;
    logic            ring_push, ring_pop, clr_one;
    logic [FW-1:0]   push_frame, clr_frame;
    logic [SW-1:0]   scan_cyc;

    // Decode what happens to the queue this cycle.
    always_comb begin
        idle       = (state_q == SC_IDLE);
        scan       = (state_q == SC_SCAN);
        enq_ok     = enq_valid && idle && !q_full;
        enq_rej    = enq_valid && idle && q_full;
        start      = vic_req && idle && !q_empty;
        head_ref   = ref_bits[head_frame];
        rotate     = scan && head_ref;
        take       = scan && !head_ref;
        ring_push  = enq_ok || rotate;
        ring_pop   = rotate || take;
        push_frame = rotate ? head_frame : enq_frame;
        clr_one    = enq_ok || rotate;
        clr_frame  = rotate ? head_frame : enq_frame;
    end

    sc_ring #(.DEPTH(NUM_FRAMES), .DW(FW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ring_push),
        .push_data (push_frame),
        .pop       (ring_pop),
        .head_data (head_frame),
        .full      (q_full),
        .empty     (q_empty)
    );

    sc_refbits #(.N(NUM_FRAMES), .FW(FW)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ref_valid),
        .set_idx (ref_frame),
        .clr_en  (clr_one),
        .clr_idx (clr_frame),
        .clr_all (clr_all),
        .bits    (ref_bits)
    );

    // Search state machine and registered responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SC_IDLE;
            vic_valid <= 1'b0;
            vic_frame <= '0;
            enq_err   <= 1'b0;
        end else begin
            vic_valid <= take;
            enq_err   <= enq_rej;
            if (take) vic_frame <= head_frame;
            if (start)     state_q <= SC_SCAN;
            else if (take) state_q <= SC_IDLE;
        end
    end

    assign vic_busy = scan;

    // Count scan cycles to bound the search length.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan) scan_cyc <= '0;
        else                 scan_cyc <= scan_cyc + 1'b1;
    end

    // R6
    vic_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |=> !vic_valid);
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vic_busy) |-> $past(vic_req));
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> !vic_busy);
    // R9
    enq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_err |-> $past(q_full));
    // R7
    search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vic_busy |-> (scan_cyc <= SW'(NUM_FRAMES)));
endmodule

// File: tb/sim_sc_victim_sel.sv
module sim_sc_victim_sel;
    localparam int NF = 4;
    localparam int FW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic [FW-1:0] enq_frame = '0;
    logic          enq_err;
    logic          ref_valid = 1'b0;
    logic [FW-1:0] ref_frame = '0;
    logic          clr_all = 1'b0;
    logic          vic_req = 1'b0;
    logic          vic_busy;
    logic          vic_valid;
    logic [FW-1:0] vic_frame;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int mq [NF];
    int mn = 0;
    bit mref [NF];

    always #10 clk = ~clk;

    sc_victim_sel #(.NUM_FRAMES(NF)) u0 (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_frame(enq_frame), .enq_err(enq_err),
        .ref_valid(ref_valid), .ref_frame(ref_frame), .clr_all(clr_all),
        .vic_req(vic_req), .vic_busy(vic_busy), .vic_valid(vic_valid),
        .vic_frame(vic_frame)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_enq(int f);
        bit exp_err;
        exp_err = (mn == NF);
        enq_valid = 1'b1;
        enq_frame = FW'(f);
        tick();
        enq_valid = 1'b0;
        chk("R9 enq_err", int'(enq_err), int'(exp_err));
        if (!exp_err) begin
            mq[mn] = f;
            mn++;
            mref[f] = 1'b0;
        end
    endtask

    task automatic do_ref(int f);
        ref_valid = 1'b1;
        ref_frame = FW'(f);
        tick();
        ref_valid = 1'b0;
        mref[f] = 1'b1;
    endtask

    task automatic do_clr;
        clr_all = 1'b1;
        tick();
        clr_all = 1'b0;
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
    endtask

    // Model the second-chance walk, then run the handshake and compare.
    task automatic do_victim(string tag, int sneak);
        int k;
        int h;
        int exp_f;
        int cnt;
        bit got;
        k = 0;
        while (mref[mq[0]]) begin
            mref[mq[0]] = 1'b0;
            h = mq[0];
            for (int i = 0; i < mn - 1; i++) mq[i] = mq[i+1];
            mq[mn-1] = h;
            k++;
        end
        exp_f = mq[0];
        for (int i = 0; i < mn - 1; i++) mq[i] = mq[i+1];
        mn--;
        vic_req = 1'b1;
        tick();
        vic_req = 1'b0;
        chk({tag, " R8 busy after accept"}, int'(vic_busy), 1);
        if (sneak >= 0) begin
            enq_valid = 1'b1;
            enq_frame = FW'(sneak);
        end
        cnt = 0;
        got = 1'b0;
        for (int i = 0; i < 3 * NF && !got; i++) begin
            tick();
            enq_valid = 1'b0;
            cnt++;
            if (sneak >= 0 && cnt == 1) chk("R10 no error while busy", int'(enq_err), 0);
            if (vic_valid) got = 1'b1;
        end
        chk({tag, " R6 latency"}, cnt, k + 1);
        chk({tag, " R6 victim frame"}, int'(vic_frame), exp_f);
        chk({tag, " R8 busy low with valid"}, int'(vic_busy), 0);
        tick();
        chk({tag, " R6 single pulse"}, int'(vic_valid), 0);
    endtask

    task automatic drain(string tag);
        while (mn > 0) do_victim(tag, -1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 reset busy", int'(vic_busy), 0);
        chk("R1 reset valid", int'(vic_valid), 0);
        chk("R1 reset err", int'(enq_err), 0);

        // Request on an empty queue is ignored.
        vic_req = 1'b1;
        tick();
        vic_req = 1'b0;
        chk("R8 empty request busy", int'(vic_busy), 0);
        tick();
        chk("R8 empty request valid", int'(vic_valid), 0);

        // R1: bits clear from reset, so the head goes at once.
        for (int i = 0; i < NF; i++) do_enq(i);
        do_victim("R1 fresh bits", -1);
        drain("R4 drain");

        // Sweep every reference pattern over a full, rotated queue.
        for (int p = 0; p < (1 << NF); p++) begin
            for (int i = 0; i < NF; i++) do_enq((p + i) % NF);
            do_enq(p % NF);
            for (int i = 0; i < NF; i++)
                if (p[i]) do_ref(i);
            if (p == (1 << NF) - 1) do_victim("R7 all set", -1);
            else                    do_victim("R5 sweep", -1);
            drain("R4 drain");
        end

        // R1: bulk clear wipes every bit.
        for (int i = 0; i < NF; i++) do_enq(i);
        for (int i = 0; i < NF; i++) do_ref(i);
        do_clr();
        do_victim("R1 bulk clear", -1);
        drain("R4 drain");

        // R2: a reference beats a bulk clear in the same cycle.
        for (int i = 0; i < NF; i++) do_enq(i);
        do_ref(0);
        do_ref(1);
        clr_all = 1'b1;
        ref_valid = 1'b1;
        ref_frame = FW'(0);
        tick();
        clr_all = 1'b0;
        ref_valid = 1'b0;
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        mref[0] = 1'b1;
        do_victim("R2 ref beats clear", -1);
        drain("R4 drain");

        // R3: enqueue clears a stale bit.
        do_ref(2);
        do_enq(2);
        do_enq(3);
        do_victim("R3 enqueue clears bit", -1);
        drain("R4 drain");

        // R10: enqueue during a search is ignored.
        do_enq(0);
        do_enq(1);
        do_enq(2);
        do_ref(0);
        do_ref(1);
        do_victim("R10 enqueue while busy", 3);
        drain("R10 drain");
        vic_req = 1'b1;
        tick();
        vic_req = 1'b0;
        chk("R10 queue empty after drain", int'(vic_busy), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule